// File: doc/BRIEF.md
# Expansion Bus Master Requester

This block is the mastering side of an expansion card that borrows the system bus. The card's local logic raises a work-pending level. The block then tells the central arbiter that it wants bus time by sending a single-clock low pulse on its private request line, and it waits for its private grant. Each grant entitles it to one full bus cycle, which it opens by driving the active-low cycle strobe. Inside that full cycle it may chain several transfers, but only when both the local logic and the addressed slave agree to chain.

The request line is a toggle and not a level. The same one-clock pulse that registers the card also unregisters it. The block keeps its own record of whether it is registered, so pulses always alternate correctly. On the last full cycle it needs, the block sends the unregister pulse in the same clock that ends the cycle. If a grant arrives when there is no work, the block gives the bus back without opening a cycle. A bus error ends the cycle at once, and the block retries the same cycle at the next grant. A second error stops the retries and sets a sticky flag that software can read. A timeout input from the bus side tells the block that its registration was dropped. The block then counts itself unregistered and does not send a pulse.

Top module: `xbus_master_req`

## Requirements
- R1: While `rst` is high and in the clock after it is released, `req_n` and `strobe_n` are 1 and `err_flag` is 0.
- R2: While unregistered, `work_pending`=1 causes `req_n` to go to 0 for exactly one clock, starting at the next clock edge, and then return to 1.
- R3: While registered and waiting, the block sends no further pulse and keeps `strobe_n`=1 until `grant_n`=0 is sampled.
- R4: When `grant_n`=0 is sampled with work pending, `strobe_n` goes to 0 at the next edge. It stays 0 until a terminating `xfer_ack`, whatever `grant_n` does in the meantime.
- R5: An `xfer_ack` does not end the full cycle while `more_xfers`=1 and `slave_multi`=1 and fewer than MAX_XFERS (default 4) transfers have completed. The ack that completes transfer MAX_XFERS, or any ack without both chain inputs, ends the cycle.
- R6: If `last_xfer`=1 at the ack that ends a full cycle, `req_n` goes to 0 in the same clock that `strobe_n` returns to 1, and the block becomes unregistered.
- R7: A grant sampled while registered, with no work pending and no retry outstanding, produces an unregister pulse, and `strobe_n` stays 1.
- R8: A `bus_err` during a full cycle returns `strobe_n` to 1 at the next edge. The cycle reopens at the next grant even when `work_pending` is 0, and `err_flag` is not set.
- R9: A `bus_err` on the retried cycle (MAX_RETRY=1 by default) sets `err_flag` to 1. The flag stays 1 until reset, and no further retry is made.
- R10: `reg_lost`=1 while registered makes the block unregistered without a pulse and releases `strobe_n`. Later grants are ignored, and the next `work_pending` sends a fresh register pulse.
- R11: Two pulses on `req_n` are always separated by at least one clock with `req_n`=1, even when work returns just after unregistering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| work_pending | input | 1 | Local logic has transfers to run |
| last_xfer | input | 1 | Current full cycle is the last one needed |
| xfer_ack | input | 1 | Slave terminated the current transfer |
| more_xfers | input | 1 | Local logic wants to chain another transfer |
| slave_multi | input | 1 | Addressed slave accepts chained transfers |
| bus_err | input | 1 | Bus error on the current transfer |
| grant_n | input | 1 | Private grant from the arbiter, active low |
| reg_lost | input | 1 | Registration dropped by bus timeout |
| req_n | output | 1 | Private register/unregister pulse, active low |
| strobe_n | output | 1 | Full-cycle strobe, active low |
| err_flag | output | 1 | Sticky retry-failure flag for software |

## Verification
The bench goes after the pulse boundaries. One case is a re-registration straight after an unregister: a design that merges the two would hold `req_n` low for two clocks. Another is the unregister pulse at the final ack: a late pulse would keep the block registered for a cycle it does not need. The retry path is driven with work removed before the retried grant. A design that retries only when work is pending would drop the failed cycle, and one that counts wrongly would set the flag on the first error or never set it. The bench also grants a card that no longer has work, and grants one whose registration was lost, to catch a strobe that opens without the right to hold the bus.

// File: rtl/xbus_req_pkg.sv
package xbus_req_pkg;

    typedef enum logic [1:0] {
        ST_UNREG = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CYCLE = 2'd2
    } req_state_e;

    typedef struct packed {
        logic ack;
        logic err;
        logic chain;
        logic last;
    } term_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/xbus_req_pulse.sv
module xbus_req_pulse (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic ready,
    output logic pulse_n
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else begin
            active_q <= fire && !active_q;
        end
    end

    assign ready   = !active_q;
    assign pulse_n = !active_q;
endmodule

// File: rtl/xbus_req_retry.sv
module xbus_req_retry #(
    parameter int unsigned MAX_RETRY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic err_in,
    input  logic clear,
    output logic pending,
    output logic give_up,
    output logic flag
);
    localparam int unsigned CW = xbus_req_pkg::cnt_width(MAX_RETRY + 1);

    logic [CW-1:0] tries_q;
    logic          flag_q;

    assign pending = (tries_q != '0);
    assign give_up = err_in && (tries_q == CW'(MAX_RETRY));
    assign flag    = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tries_q <= '0;
            flag_q  <= 1'b0;
        end else if (give_up) begin
            tries_q <= '0;
            flag_q  <= 1'b1;
        end else if (clear) begin
            tries_q <= '0;
        end else if (err_in) begin
            tries_q <= tries_q + 1'b1;
        end
    end
endmodule

// File: rtl/xbus_req_xfer.sv
module xbus_req_xfer #(
    parameter int unsigned MAX_XFERS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_cycle,
    input  logic ack,
    input  logic chain,
    output logic keep
);
    localparam int unsigned CW = xbus_req_pkg::cnt_width(MAX_XFERS);

    logic [CW-1:0] done_q;

    assign keep = chain && (done_q < CW'(MAX_XFERS - 1));

    always_ff @(posedge clk) begin
        if (rst || !in_cycle) begin
            done_q <= '0;
        end else if (ack && keep) begin
            done_q <= done_q + 1'b1;
        end
    end
endmodule

// File: rtl/xbus_master_req.sv
module xbus_master_req #(
    parameter int unsigned MAX_XFERS = 4,
    parameter int unsigned MAX_RETRY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic work_pending,
    input  logic last_xfer,
    input  logic xfer_ack,
    input  logic more_xfers,
    input  logic slave_multi,
    input  logic bus_err,
    input  logic grant_n,
    input  logic reg_lost,
    output logic req_n,
    output logic strobe_n,
    output logic err_flag
);
    import xbus_req_pkg::*;

    req_state_e state_q, state_d;
    term_t      term;
    logic       fire, pulse_ready, in_cycle;
    logic       keep, cycle_end, lost_now;
    logic       retry_pend, give_up;

    assign in_cycle   = (state_q == ST_CYCLE);
    assign term.err   = in_cycle && bus_err;
    assign term.ack   = in_cycle && xfer_ack && !bus_err;
    assign term.chain = more_xfers && slave_multi;
    assign term.last  = last_xfer;
    assign cycle_end  = term.ack && !keep;
    assign lost_now   = reg_lost && (state_q != ST_UNREG);

    xbus_req_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .ready   (pulse_ready),
        .pulse_n (req_n)
    );

    xbus_req_xfer #(.MAX_XFERS(MAX_XFERS)) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .in_cycle (in_cycle),
        .ack      (term.ack),
        .chain    (term.chain),
        .keep     (keep)
    );

    xbus_req_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk     (clk),
        .rst     (rst),
        .err_in  (term.err),
        .clear   (cycle_end || lost_now),
        .pending (retry_pend),
        .give_up (give_up),
        .flag    (err_flag)
    );

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (lost_now) begin
            state_d = ST_UNREG;
        end else begin
            unique case (state_q)
                ST_UNREG: begin
                    if (work_pending && pulse_ready) begin
                        fire    = 1'b1;
                        state_d = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!grant_n && pulse_ready) begin
                        if (work_pending || retry_pend) begin
                            state_d = ST_CYCLE;
                        end else begin
                            fire    = 1'b1;
                            state_d = ST_UNREG;
                        end
                    end
                end
                ST_CYCLE: begin
                    if ((term.err && give_up) || cycle_end) begin
                        if (term.last && pulse_ready) begin
                            fire    = 1'b1;
                            state_d = ST_UNREG;
                        end else begin
                            state_d = ST_WAIT;
                        end
                    end else if (term.err) begin
                        state_d = ST_WAIT;
                    end
                end
                default: state_d = ST_UNREG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UNREG;
        end else begin
            state_q <= state_d;
        end
    end

    assign strobe_n = !in_cycle;
endmodule

// File: rtl/xbus_master_req_chk.sv
module xbus_master_req_chk (
    input logic clk,
    input logic rst,
    input logic bus_err,
    input logic grant_n,
    input logic reg_lost,
    input logic req_n,
    input logic strobe_n,
    input logic err_flag
);
    logic shadow_q;

    always_ff @(posedge clk) begin
        if (rst || reg_lost) begin
            shadow_q <= 1'b0;
        end else if (!req_n) begin
            shadow_q <= !shadow_q;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_n && strobe_n && !err_flag));

    assert_pulse_one_clk_R2: assert property (@(posedge clk) disable iff (rst)
        !req_n |=> req_n);

    assert_strobe_registered_R3: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> shadow_q);

    assert_strobe_after_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> $past(!grant_n));

    assert_err_release_R8: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && bus_err) |=> strobe_n);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(bus_err && !strobe_n));

    assert_lost_release_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_lost && !strobe_n) |=> (strobe_n && req_n));
endmodule

bind xbus_master_req xbus_master_req_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_err  (bus_err),
    .grant_n  (grant_n),
    .reg_lost (reg_lost),
    .req_n    (req_n),
    .strobe_n (strobe_n),
    .err_flag (err_flag)
);

// File: tb/xbus_master_req_bench.sv
module xbus_master_req_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic work_pending = 1'b0, last_xfer = 1'b0, xfer_ack = 1'b0;
    logic more_xfers = 1'b0, slave_multi = 1'b0, bus_err = 1'b0;
    logic grant_n = 1'b1, reg_lost = 1'b0;
    logic req_n, strobe_n, err_flag;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #10 clk = !clk;

    xbus_master_req u_xbus_master_req (
        .clk(clk), .rst(rst), .work_pending(work_pending), .last_xfer(last_xfer),
        .xfer_ack(xfer_ack), .more_xfers(more_xfers), .slave_multi(slave_multi),
        .bus_err(bus_err), .grant_n(grant_n), .reg_lost(reg_lost),
        .req_n(req_n), .strobe_n(strobe_n), .err_flag(err_flag)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        work_pending = 0; last_xfer = 0; xfer_ack = 0; more_xfers = 0;
        slave_multi = 0; bus_err = 0; grant_n = 1; reg_lost = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    // register, then take one grant; leaves strobe_n low
    task automatic reg_and_grant();
        work_pending = 1'b1;
        tick(); tick();
        grant_n = 1'b0; tick(); grant_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        tick();
        chk("R1", "req_n", req_n, 1'b1);
        chk("R1", "strobe_n", strobe_n, 1'b1);
        chk("R1", "err_flag", err_flag, 1'b0);
    endtask

    task automatic t_register();
        do_reset();
        work_pending = 1'b1;
        tick(); chk("R2", "req_n pulse low", req_n, 1'b0);
        tick(); chk("R2", "req_n back high", req_n, 1'b1);
        repeat (3) tick();
        chk("R3", "no repeat pulse", req_n, 1'b1);
        chk("R3", "idle before grant", strobe_n, 1'b1);
        grant_n = 1'b0; tick();
        chk("R4", "strobe after grant", strobe_n, 1'b0);
        grant_n = 1'b1; tick();
        chk("R4", "strobe held", strobe_n, 1'b0);
        xfer_ack = 1'b1; tick(); xfer_ack = 1'b0;
        chk("R4", "strobe released at ack", strobe_n, 1'b1);
        chk("R3", "still registered", req_n, 1'b1);
    endtask

    task automatic t_last();
        do_reset();
        reg_and_grant();
        xfer_ack = 1'b1; last_xfer = 1'b1; tick();
        xfer_ack = 1'b0; last_xfer = 1'b0;
        chk("R6", "strobe released", strobe_n, 1'b1);
        chk("R6", "unregister pulse", req_n, 1'b0);
        tick(); chk("R11", "gap between pulses", req_n, 1'b1);
        tick(); chk("R11", "re-register pulse", req_n, 1'b0);
        tick(); chk("R11", "re-register ends", req_n, 1'b1);
    endtask

    task automatic t_multi();
        do_reset();
        reg_and_grant();
        more_xfers = 1'b1; slave_multi = 1'b1; xfer_ack = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(); chk("R5", "chained transfer keeps strobe", strobe_n, 1'b0);
        end
        tick(); chk("R5", "limit ends full cycle", strobe_n, 1'b1);
        xfer_ack = 1'b0;
        grant_n = 1'b0; tick(); grant_n = 1'b1;
        chk("R5", "second cycle opens", strobe_n, 1'b0);
        slave_multi = 1'b0; xfer_ack = 1'b1; tick();
        xfer_ack = 1'b0; more_xfers = 1'b0;
        chk("R5", "slave refuses chaining", strobe_n, 1'b1);
    endtask

    task automatic t_unused();
        do_reset();
        work_pending = 1'b1; tick(); tick();
        work_pending = 1'b0; grant_n = 1'b0; tick();
        chk("R7", "unused grant unregisters", req_n, 1'b0);
        chk("R7", "no strobe", strobe_n, 1'b1);
        grant_n = 1'b1; tick();
        chk("R7", "pulse ends", req_n, 1'b1);
        chk("R7", "still no strobe", strobe_n, 1'b1);
    endtask

    task automatic t_retry();
        do_reset();
        reg_and_grant();
        bus_err = 1'b1; tick(); bus_err = 1'b0;
        chk("R8", "error drops strobe", strobe_n, 1'b1);
        chk("R8", "no flag on first error", err_flag, 1'b0);
        work_pending = 1'b0; grant_n = 1'b0; tick(); grant_n = 1'b1;
        chk("R8", "retry without work", strobe_n, 1'b0);
        xfer_ack = 1'b1; tick(); xfer_ack = 1'b0;
        chk("R8", "retry completes", strobe_n, 1'b1);
        chk("R8", "flag still clear", err_flag, 1'b0);
    endtask

    task automatic t_double();
        do_reset();
        reg_and_grant();
        bus_err = 1'b1; tick(); bus_err = 1'b0;
        grant_n = 1'b0; tick(); grant_n = 1'b1;
        chk("R9", "retried cycle open", strobe_n, 1'b0);
        bus_err = 1'b1; tick(); bus_err = 1'b0;
        chk("R9", "second error drops strobe", strobe_n, 1'b1);
        chk("R9", "flag raised", err_flag, 1'b1);
        work_pending = 1'b0; grant_n = 1'b0; tick(); grant_n = 1'b1;
        chk("R9", "no third attempt", strobe_n, 1'b1);
        chk("R9", "grant returned unused", req_n, 1'b0);
        tick(); chk("R9", "flag sticky", err_flag, 1'b1);
    endtask

    task automatic t_lost();
        do_reset();
        work_pending = 1'b1; tick(); tick();
        reg_lost = 1'b1; tick(); reg_lost = 1'b0;
        chk("R10", "no pulse on timeout", req_n, 1'b1);
        tick(); chk("R10", "fresh register pulse", req_n, 1'b0);
        do_reset();
        reg_and_grant();
        reg_lost = 1'b1; tick(); reg_lost = 1'b0;
        chk("R10", "strobe released", strobe_n, 1'b1);
        chk("R10", "no pulse", req_n, 1'b1);
        work_pending = 1'b0; grant_n = 1'b0; tick(); grant_n = 1'b1;
        chk("R10", "grant ignored", strobe_n, 1'b1);
        chk("R10", "no unregister pulse", req_n, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all R): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_register();
        t_last();
        t_multi();
        t_unused();
        t_retry();
        t_double();
        t_lost();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule